// File: doc/BRIEF.md
# Two-Hand Clock Frame Reclaimer

The block tracks a pool of physical memory frames and hands back frames that have not been touched recently. Each frame carries a used flag and a dirty flag. Memory references arriving on the reference port set the used flag, and a write reference also sets the dirty flag. Two sweep hands walk the pool together, a fixed number of frames apart. The clearing hand wipes the used flag of the frame it passes. The reclaiming hand trails it and looks at a frame after the clearing hand has gone by.

When the reclaiming hand finds a frame that is still unused, that frame leaves the pool. A clean frame goes onto a free-frame FIFO, which an allocator drains through the pop port. A dirty frame goes onto a write-back request FIFO instead. A disk engine outside the block takes requests from that FIFO and reports completion on the done port. Completion makes the frame clean again, so a later pass can free it. Sweeping stops while enough free frames are already waiting, and it also stops while the write-back FIFO is full.

Top module: `clock_reclaimer`

## Requirements
- R1: While reset is held and on the first cycle after it, `freeValid` and `wbValid` are 0, and every frame is unused, clean and unqueued.
- R2: The clearing hand starts at frame 0 after reset. Each sweep step moves it forward by one, wrapping from NUM_FRAMES-1 to 0. In that step the reclaiming hand inspects frame (clearing hand − HAND_GAP) mod NUM_FRAMES, so the first frame inspected after reset is NUM_FRAMES−HAND_GAP. When no step is taken, neither hand moves.
- R3: A reference with `refValid`=1 sets the used flag of `refFrame`. If `refWrite`=1 as well, it also sets that frame's dirty flag.
- R4: If the inspected frame is unused, clean and unqueued, it is pushed onto the free FIFO. Frames come out of `freeFrame` in the order they were inspected.
- R5: If the inspected frame is unused, dirty and unqueued, it is pushed onto the write-back FIFO and not onto the free FIFO. Each step pushes at most one frame.
- R6: A reference to the frame being cleared in the same cycle leaves its used flag set. A reference to the frame being inspected in the same cycle stops that frame from being reclaimed in that step.
- R7: While a frame sits on the free FIFO, it is never queued again. While a frame has a write-back pending, from its push until its done report, it is never queued again.
- R8: A `wbDone` pulse for a pending frame clears that frame's dirty flag and its pending mark, unless a write reference to the same frame arrives in the same cycle, in which case the frame stays dirty. A later pass may then free the frame.
- R9: Whether a step is taken is decided from the state at the start of the cycle. No step is taken while the free FIFO holds FREE_THRESH or more frames, or while the write-back FIFO holds WB_DEPTH entries.
- R10: `freePop`=1 with `freeValid`=1 removes the head frame, and `wbTake`=1 with `wbValid`=1 removes the head request. On an empty FIFO both inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A reference is presented this cycle |
| refFrame | input | IDXW | Frame being referenced |
| refWrite | input | 1 | The reference is a write |
| freePop | input | 1 | Allocator takes the free FIFO head |
| freeValid | output | 1 | Free FIFO is not empty |
| freeFrame | output | IDXW | Frame at the free FIFO head |
| wbTake | input | 1 | Disk engine takes the write-back head |
| wbValid | output | 1 | Write-back FIFO is not empty |
| wbFrame | output | IDXW | Frame at the write-back head |
| wbDone | input | 1 | A write-back has finished |
| wbDoneFrame | input | IDXW | Frame whose write-back finished |

## Verification
A used or dirty flag that is wrong stays invisible until the reclaiming hand reaches that frame, which can be up to NUM_FRAMES steps later, plus any cycles spent paused. At that point the frame appears on the wrong FIFO, appears when it should not, or is missing. A hand that is off by one shows on the first reclaim after reset. A lost queued mark shows as the same frame number sitting in a FIFO twice. A cycle-level reference model in the bench compares both FIFO heads every cycle under random references, pops, takes and completions, so each of these faults is caught at the first cycle it reaches a port.

// File: rtl/clock_reclaim_pkg.sv
package clock_reclaim_pkg;
  // Strobes from sweep control to the frame datapath.
  typedef struct packed {
    logic sweep;     // a sweep step happens this cycle
    logic pushFree;  // inspected frame goes to the free FIFO
    logic pushWb;    // inspected frame goes to the write-back FIFO
  } sweep_ctl_t;
endpackage

// File: rtl/reclaim_fifo.sv
module reclaim_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= pushData;
        wrPtr <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head = store[rdPtr];

  // R7: unique queueing keeps the FIFO within its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != CW'(DEPTH)) || pop);
endmodule

// File: rtl/reclaim_datapath.sv
module reclaim_datapath
  import clock_reclaim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int WB_DEPTH = 2,
  localparam int IDXW = $clog2(NUM_FRAMES),
  localparam int FCW = $clog2(NUM_FRAMES + 1),
  localparam int WCW = $clog2(WB_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refValid,
  input  logic [IDXW-1:0] refFrame,
  input  logic            refWrite,
  input  sweep_ctl_t      ctl,
  input  logic [IDXW-1:0] clrIdx,
  input  logic [IDXW-1:0] inspIdx,
  input  logic            freePop,
  input  logic            wbTake,
  input  logic            wbDone,
  input  logic [IDXW-1:0] wbDoneFrame,
  output logic            inspUsed,
  output logic            inspDirty,
  output logic            inspQueued,
  output logic [FCW-1:0]  freeCount,
  output logic            wbFull,
  output logic            freeValid,
  output logic [IDXW-1:0] freeFrame,
  output logic            wbValid,
  output logic [IDXW-1:0] wbFrame
);
  logic [NUM_FRAMES-1:0] usedBits, dirtyBits, freeBits, pendBits;
  logic [WCW-1:0] wbCount;
  logic freePopEff, wbTakeEff;

  assign freeValid  = (freeCount != '0);
  assign wbValid    = (wbCount != '0);
  assign wbFull     = (wbCount == WCW'(WB_DEPTH));
  assign freePopEff = freePop && freeValid;
  assign wbTakeEff  = wbTake && wbValid;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    logic refHit, wrHit, clrHit, doneHit, freeOut;
    assign refHit  = refValid && (refFrame == IDXW'(i));
    assign wrHit   = refHit && refWrite;
    assign clrHit  = ctl.sweep && (clrIdx == IDXW'(i));
    assign doneHit = wbDone && (wbDoneFrame == IDXW'(i));
    assign freeOut = freePopEff && (freeFrame == IDXW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        usedBits[i]  <= 1'b0;
        dirtyBits[i] <= 1'b0;
        freeBits[i]  <= 1'b0;
        pendBits[i]  <= 1'b0;
      end else begin
        if (refHit) usedBits[i] <= 1'b1;
        else if (clrHit) usedBits[i] <= 1'b0;
        if (wrHit) dirtyBits[i] <= 1'b1;
        else if (doneHit) dirtyBits[i] <= 1'b0;
        if (ctl.pushFree && inspIdx == IDXW'(i)) freeBits[i] <= 1'b1;
        else if (freeOut) freeBits[i] <= 1'b0;
        if (ctl.pushWb && inspIdx == IDXW'(i)) pendBits[i] <= 1'b1;
        else if (doneHit) pendBits[i] <= 1'b0;
      end
    end
  end

  // A same-cycle reference to the inspected frame protects it.
  assign inspUsed   = usedBits[inspIdx] || (refValid && refFrame == inspIdx);
  assign inspDirty  = dirtyBits[inspIdx];
  assign inspQueued = freeBits[inspIdx] || pendBits[inspIdx];

  reclaim_fifo #(.DEPTH(NUM_FRAMES), .W(IDXW)) freeQ_i (
    .clk(clk), .rstN(rstN), .push(ctl.pushFree), .pushData(inspIdx),
    .pop(freePopEff), .head(freeFrame), .count(freeCount));

  reclaim_fifo #(.DEPTH(WB_DEPTH), .W(IDXW)) wbQ_i (
    .clk(clk), .rstN(rstN), .push(ctl.pushWb), .pushData(inspIdx),
    .pop(wbTakeEff), .head(wbFrame), .count(wbCount));

  // R6: a reference always leaves the used flag set
  a_r6_ref_wins: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> usedBits[$past(refFrame)]);

  // R3: a write reference marks the frame dirty
  a_r3_write_dirty: assert property (@(posedge clk) disable iff (!rstN)
    refValid && refWrite |=> dirtyBits[$past(refFrame)]);

  // R7: a frame already queued is never pushed again
  a_r7_no_dup: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushFree || ctl.pushWb) |-> !freeBits[inspIdx] && !pendBits[inspIdx]);

  // R8: completion leaves the frame clean and unpending
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    wbDone && !(refValid && refWrite && refFrame == wbDoneFrame)
      |=> !dirtyBits[$past(wbDoneFrame)] && !pendBits[$past(wbDoneFrame)]);
endmodule

// File: rtl/reclaim_control.sv
module reclaim_control
  import clock_reclaim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int HAND_GAP = 3,
  parameter int FREE_THRESH = 4,
  localparam int IDXW = $clog2(NUM_FRAMES),
  localparam int FCW = $clog2(NUM_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [FCW-1:0]  freeCount,
  input  logic            wbFull,
  input  logic            inspUsed,
  input  logic            inspDirty,
  input  logic            inspQueued,
  output sweep_ctl_t      ctl,
  output logic [IDXW-1:0] clrIdx,
  output logic [IDXW-1:0] inspIdx
);
  localparam logic [IDXW-1:0] GapL = IDXW'(HAND_GAP);
  localparam logic [IDXW-1:0] BackL = IDXW'(NUM_FRAMES - HAND_GAP);
  localparam logic [IDXW-1:0] LastL = IDXW'(NUM_FRAMES - 1);

  logic [IDXW-1:0] clearHand;
  logic reclaimable;

  assign clrIdx  = clearHand;
  assign inspIdx = (clearHand >= GapL) ? clearHand - GapL : clearHand + BackL;

  assign reclaimable  = !inspUsed && !inspQueued;
  assign ctl.sweep    = (freeCount < FCW'(FREE_THRESH)) && !wbFull;
  assign ctl.pushFree = ctl.sweep && reclaimable && !inspDirty;
  assign ctl.pushWb   = ctl.sweep && reclaimable && inspDirty;

  always_ff @(posedge clk) begin
    if (!rstN) clearHand <= '0;
    else if (ctl.sweep) clearHand <= (clearHand == LastL) ? '0 : clearHand + 1'b1;
  end

  // R2: the hands hold still when no step is taken
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.sweep |=> $stable(clearHand));

  // R5: at most one destination per step
  a_r5_one_route: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.pushFree, ctl.pushWb}));
endmodule

// File: rtl/clock_reclaimer.sv
module clock_reclaimer
  import clock_reclaim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int HAND_GAP = 3,
  parameter int FREE_THRESH = 4,
  parameter int WB_DEPTH = 2,
  localparam int IDXW = $clog2(NUM_FRAMES),
  localparam int FCW = $clog2(NUM_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refValid,
  input  logic [IDXW-1:0] refFrame,
  input  logic            refWrite,
  input  logic            freePop,
  output logic            freeValid,
  output logic [IDXW-1:0] freeFrame,
  input  logic            wbTake,
  output logic            wbValid,
  output logic [IDXW-1:0] wbFrame,
  input  logic            wbDone,
  input  logic [IDXW-1:0] wbDoneFrame
);
  sweep_ctl_t ctl;
  logic [IDXW-1:0] clrIdx, inspIdx;
  logic [FCW-1:0] freeCount;
  logic wbFull, inspUsed, inspDirty, inspQueued;

  reclaim_control #(.NUM_FRAMES(NUM_FRAMES), .HAND_GAP(HAND_GAP),
                    .FREE_THRESH(FREE_THRESH)) ctrl_i (
    .clk(clk), .rstN(rstN), .freeCount(freeCount), .wbFull(wbFull),
    .inspUsed(inspUsed), .inspDirty(inspDirty), .inspQueued(inspQueued),
    .ctl(ctl), .clrIdx(clrIdx), .inspIdx(inspIdx));

  reclaim_datapath #(.NUM_FRAMES(NUM_FRAMES), .WB_DEPTH(WB_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFrame(refFrame),
    .refWrite(refWrite), .ctl(ctl), .clrIdx(clrIdx), .inspIdx(inspIdx),
    .freePop(freePop), .wbTake(wbTake), .wbDone(wbDone),
    .wbDoneFrame(wbDoneFrame), .inspUsed(inspUsed), .inspDirty(inspDirty),
    .inspQueued(inspQueued), .freeCount(freeCount), .wbFull(wbFull),
    .freeValid(freeValid), .freeFrame(freeFrame), .wbValid(wbValid),
    .wbFrame(wbFrame));
endmodule

// File: tb/clock_reclaimer_tb_top.sv
module clock_reclaimer_tb_top;
  localparam int N = 8;
  localparam int GAP = 3;
  localparam int THRESH = 4;
  localparam int WBD = 2;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0, refWrite = 1'b0, freePop = 1'b0, wbTake = 1'b0, wbDone = 1'b0;
  logic [IW-1:0] refFrame = '0, wbDoneFrame = '0;
  logic freeValid, wbValid;
  logic [IW-1:0] freeFrame, wbFrame;

  int checks = 0;
  int failures = 0;

  // model state
  bit mUsed[N], mDirty[N], mFree[N], mPend[N];
  int mHand = 0;
  int fq[$];
  int wq[$];
  int taken[$];

  always #10 clk = ~clk;

  clock_reclaimer #(.NUM_FRAMES(N), .HAND_GAP(GAP), .FREE_THRESH(THRESH),
                    .WB_DEPTH(WBD)) dut_i (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFrame(refFrame),
    .refWrite(refWrite), .freePop(freePop), .freeValid(freeValid),
    .freeFrame(freeFrame), .wbTake(wbTake), .wbValid(wbValid),
    .wbFrame(wbFrame), .wbDone(wbDone), .wbDoneFrame(wbDoneFrame));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int inspOf(input int h);
    return (h - GAP + N) % N;
  endfunction

  function automatic bit modelSweep();
    return (fq.size() < THRESH) && (wq.size() < WBD);
  endfunction

  // Advance the model by one cycle with the given inputs.
  function automatic void modelStep(input bit rv, input int rf, input bit rw,
                                    input bit pp, input bit tk,
                                    input bit dn, input int df);
    bit sw = modelSweep();
    int ins = inspOf(mHand);
    bit used = mUsed[ins] || (rv && rf == ins);
    bit pf = 0, pw = 0;
    if (sw && !used && !mFree[ins] && !mPend[ins]) begin
      if (mDirty[ins]) pw = 1; else pf = 1;
    end
    if (pp && fq.size() > 0) begin
      int f = fq.pop_front();
      mFree[f] = 0;
    end
    if (tk && wq.size() > 0) begin
      int w = wq.pop_front();
      taken.push_back(w);
    end
    if (dn) begin
      mPend[df] = 0;
      mDirty[df] = 0;
    end
    if (sw) mUsed[mHand] = 0;
    if (rv) begin
      mUsed[rf] = 1;
      if (rw) mDirty[rf] = 1;
    end
    if (pf) begin fq.push_back(ins); mFree[ins] = 1; end
    if (pw) begin wq.push_back(ins); mPend[ins] = 1; end
    if (sw) mHand = (mHand + 1) % N;
  endfunction

  // Called at a falling edge: drive, step model, compare at next falling edge.
  task automatic step(input string tag, input bit rv, input int rf, input bit rw,
                      input bit pp, input bit tk, input bit dn, input int df);
    int expF, expW;
    refValid = rv; refFrame = IW'(rf); refWrite = rw;
    freePop = pp; wbTake = tk; wbDone = dn; wbDoneFrame = IW'(df);
    modelStep(rv, rf, rw, pp, tk, dn, df);
    @(negedge clk);
    expF = (fq.size() > 0) ? 8 + fq[0] : 0;
    expW = (wq.size() > 0) ? 8 + wq[0] : 0;
    chk({tag, " free head"}, freeValid ? 8 + int'(freeFrame) : 0, expF);
    chk({tag, " wb head"}, wbValid ? 8 + int'(wbFrame) : 0, expW);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Pick a pending, already-taken frame to complete, or none.
  task automatic randomDone(output bit dn, output int df);
    dn = 0; df = 0;
    if (taken.size() > 0 && ($urandom % 3) == 0) begin
      int k = $urandom % taken.size();
      df = taken[k];
      taken.delete(k);
      dn = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit dn;
    int df;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1 freeValid in reset", int'(freeValid), 0);
    chk("R1 wbValid in reset", int'(wbValid), 0);
    rstN = 1'b1;

    // R2 R4: four idle steps free frames 5,6,7,0; head must be 5
    idle("R2 R4 first pass", 4);
    chk("R2 first reclaimed frame", int'(freeFrame), (N - GAP) % N);
    chk("R4 free valid", int'(freeValid), 1);

    // R9: free FIFO at threshold, nothing more moves
    idle("R9 paused on threshold", 6);

    // R3 R5: dirty frames route to write-back once pops let the sweep run
    step("R3 R5 write ref", 1, 1, 1, 0, 0, 0, 0);
    step("R3 R5 write ref", 1, 2, 1, 0, 0, 0, 0);
    for (int i = 0; i < 24; i++) step("R3 R5 drain", 0, 0, 0, 1, 0, 0, 0);

    // R9: write-back FIFO full pauses the sweep
    for (int i = 0; i < N; i++) step("R9 dirty fill", 1, i, 1, 0, 0, 0, 0);
    for (int i = 0; i < 30; i++) step("R9 wb full", 0, 0, 0, 1, 0, 0, 0);

    // R8: take and complete write-backs, frames later become free
    for (int i = 0; i < 40; i++) begin
      randomDone(dn, df);
      step("R8 complete", 0, 0, 0, 1, 1, dn, df);
    end

    // R6: references aimed at the hands in the same cycle
    for (int i = 0; i < 40; i++) begin
      int tgt = (i % 2 == 0) ? mHand : inspOf(mHand);
      randomDone(dn, df);
      step("R6 ref at hand", 1, tgt, i[2], 1, 1, dn, df);
    end

    // R7 R10: random traffic including pops and takes on empty FIFOs
    for (int i = 0; i < 3000; i++) begin
      bit rv = ($urandom % 2) == 0;
      randomDone(dn, df);
      step("R7 R10 random", rv, $urandom % N, ($urandom % 2) == 0,
           ($urandom % 3) == 0, ($urandom % 3) == 0, dn, df);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule